// File: doc/BRIEF.md
# Packet transmit burst sequencer

This block moves a single packet out of a transmit byte FIFO and onto a simplified 32-bit initiator write bus. A start pulse loads the packet length, the first target address and the configuration: command code, burst size, retry limit, upper-lane suppression and fixed-address mode. The block then cuts the packet into write transactions. Each transaction has one address-phase cycle that carries the command, the address and the beat count, and then one data-phase cycle for each beat. A transaction is only opened once the FIFO already holds every byte it will carry. When the remaining bytes cannot fill a whole burst, the packet is finished with single-beat transactions.

The target answers each data beat with exactly one of four responses:
- accept, which pops one FIFO word;
- retry/disconnect, which ends the transaction with that beat unsent;
- master abort;
- target abort.

After a retry the sequencer reopens the transaction at the first beat that was not accepted. Retries are counted per packet. When a nonzero limit is reached, the packet is abandoned and a one-cycle interrupt is raised. Sticky status flags report whether the packet completed or was aborted, and they stay valid until the next start.

Top module: `pkt_burst_tx`

## Requirements
- R1: `cmd_o` carries the command latched at the start pulse in every address phase. Out of reset it reads 4'h7, the memory-write code.
- R2: Full bursts use the configured beat count of 1 to 7 beats. A configured value of 0 means 8 beats. Each beat is 4 bytes.
- R3: An address phase (`req_o`) is only issued when `fifo_level_i` is at least the smaller of two values: the burst size in bytes, or the bytes still left in the packet.
- R4: When fewer bytes remain than one full burst needs, every remaining transaction has `beats_o` = 1. A full-burst packet of L bytes with B-beat bursts therefore takes floor(L/4B) + ceil((L mod 4B)/4) transactions.
- R5: The retry count belongs to one packet. It returns to zero on completion, on either abort, on a retry-limit abort and on a new start.
- R6: With a nonzero limit N, the Nth retry ends the packet, sets `abort_retry_o` and pulses `irq_o` for one cycle. With a limit of 0, `irq_o` never fires.
- R7: When the upper-lane control is set, `be_o[3:2]` is 0 on every beat. When it is clear, all lanes of a full word are enabled.
- R8: The address moves up by 4 for each accepted beat. With fixed-address mode set, every address phase of the packet shows the start address.
- R9: After a retry, the next address phase carries the address of the first unaccepted beat. Its beat count is the number of beats still left in the interrupted burst.
- R10: A master or target abort ends the packet at once and sets `abort_mst_o` or `abort_tgt_o`. The aborted beat is not popped from the FIFO.
- R11: Configuration, length and address are sampled at the start pulse. A start pulse that arrives while `busy_o` is high has no effect.
- R12: If the packet length is not a multiple of 4, the final beat enables only the low `len mod 4` lanes. Lane 0 is `data_o[7:0]`, and `be_o` bit i is lane i (1 = enabled).
- R13: `done_o` is set after the last byte is accepted. All status flags clear at the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one packet (ignored while busy) |
| pkt_len_i | input | LEN_W | Packet length in bytes |
| pkt_addr_i | input | ADDR_W | First target address |
| cfg_cmd_i | input | 4 | Command code for address phases |
| cfg_beats_i | input | 3 | Beats per burst, 0 = 8 |
| cfg_rty_lim_i | input | RTY_W | Retry limit per packet, 0 = unlimited |
| cfg_lo_half_i | input | 1 | Disable the two upper byte lanes |
| cfg_fix_addr_i | input | 1 | Keep the same address for all transactions |
| fifo_level_i | input | LVL_W | Bytes available in the FIFO |
| fifo_data_i | input | 32 | FIFO head word |
| fifo_pop_o | output | 1 | Pop FIFO head word |
| req_o | output | 1 | Address phase of a transaction |
| cmd_o | output | 4 | Command code |
| addr_o | output | ADDR_W | Transaction address |
| beats_o | output | 4 | Beats in this transaction |
| beat_valid_o | output | 1 | Data phase beat on bus |
| data_o | output | 32 | Beat data |
| be_o | output | 4 | Byte enables, active high |
| tgt_ack_i | input | 1 | Target accepts the beat |
| tgt_retry_i | input | 1 | Target retries/disconnects, beat not taken |
| tgt_mabort_i | input | 1 | Master abort |
| tgt_tabort_i | input | 1 | Target abort |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | Last packet completed |
| abort_mst_o | output | 1 | Last packet ended by master abort |
| abort_tgt_o | output | 1 | Last packet ended by target abort |
| abort_retry_o | output | 1 | Last packet ended by retry limit |
| irq_o | output | 1 | One-cycle pulse on retry-limit abort |

## Verification
The sweep with accept-always responses covers every burst setting and lengths from 1 to 33 bytes, in each combination of upper-lane and fixed-address mode. It separates the full-burst path from the single-beat tail, and it exposes off-by-one errors in the transaction count, the partial-word enables and the address step.

A FIFO level held one byte short of the need, for both a full burst and a 2-byte tail, separates a correct admission rule from a rule that is too loose.

Retries at a mid-burst beat test the reissue address and the remaining beat count. Endless retries under limits of 1, 3 and 0 separate the abort threshold from the case with no limit. Repeated single retries across packets show whether the counter really clears between packets.

Aborts at chosen beats, and a second start pulse with different settings arriving mid-packet, test the early stop and the ignore rule.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ADDR, ST_DATA} tx_state_e;

  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  // beat-count field: 0 encodes the 8-beat maximum
  function automatic logic [3:0] beats_of(input logic [2:0] fld);
    return (fld == 3'd0) ? 4'd8 : {1'b0, fld};
  endfunction
endpackage

// File: rtl/pkt_tx_plan.sv
module pkt_tx_plan import pkt_tx_pkg::*; #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] rem_i,
  input  logic [3:0]       left_i,
  input  logic [2:0]       bcfg_i,
  output logic [3:0]       beats_o,
  output logic [LEN_W-1:0] need_o
);
  logic [3:0]       full;
  logic [LEN_W-1:0] full_bytes, nb_bytes;

  always_comb begin
    full       = beats_of(bcfg_i);
    full_bytes = LEN_W'({full, 2'b00});
    // resume an interrupted burst first, else full burst or single tail beat
    if (left_i != 4'd0)          beats_o = left_i;
    else if (rem_i >= full_bytes) beats_o = full;
    else                          beats_o = 4'd1;
    nb_bytes = LEN_W'({beats_o, 2'b00});
    need_o   = (rem_i < nb_bytes) ? rem_i : nb_bytes;
  end
endmodule

// File: rtl/pkt_tx_be.sv
module pkt_tx_be #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] rem_i,
  input  logic             lo_half_i,
  output logic [3:0]       be_o
);
  logic [3:0] tail;

  always_comb begin
    if (rem_i >= LEN_W'(4)) tail = 4'b1111;
    else begin
      unique case (rem_i[1:0])
        2'd1:    tail = 4'b0001;
        2'd2:    tail = 4'b0011;
        2'd3:    tail = 4'b0111;
        default: tail = 4'b0000;
      endcase
    end
    be_o = tail & (lo_half_i ? 4'b0011 : 4'b1111);
  end
endmodule

// File: rtl/pkt_tx_retry.sv
module pkt_tx_retry #(
  parameter int RTY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [RTY_W-1:0] lim_i,
  output logic             hit_o
);
  logic [RTY_W-1:0] cnt_q;

  assign hit_o = inc_i && (lim_i != '0) && (cnt_q + RTY_W'(1) == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i || hit_o)      cnt_q <= '0;
    else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + RTY_W'(1);
  end

  // R5
  retry_below_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_i != '0) |-> (cnt_q < lim_i));

  // R5
  retry_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pkt_burst_tx.sv
module pkt_burst_tx import pkt_tx_pkg::*; #(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32,
  parameter int LVL_W  = 8,
  parameter int RTY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic [ADDR_W-1:0] pkt_addr_i,
  input  logic [3:0]        cfg_cmd_i,
  input  logic [2:0]        cfg_beats_i,
  input  logic [RTY_W-1:0]  cfg_rty_lim_i,
  input  logic              cfg_lo_half_i,
  input  logic              cfg_fix_addr_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic [31:0]       fifo_data_i,
  output logic              fifo_pop_o,
  output logic              req_o,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [3:0]        beats_o,
  output logic              beat_valid_o,
  output logic [31:0]       data_o,
  output logic [3:0]        be_o,
  input  logic              tgt_ack_i,
  input  logic              tgt_retry_i,
  input  logic              tgt_mabort_i,
  input  logic              tgt_tabort_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              abort_mst_o,
  output logic              abort_tgt_o,
  output logic              abort_retry_o,
  output logic              irq_o
);
  localparam int CMP_W = LEN_W + LVL_W;

  tx_state_e         st_q;
  logic [3:0]        cmd_q, cur_beats_q, left_q;
  logic [2:0]        bcfg_q;
  logic [RTY_W-1:0]  lim_q;
  logic              half_q, fix_q;
  logic [ADDR_W-1:0] addr_q, base_q;
  logic [LEN_W-1:0]  rem_q;
  logic              done_q, mab_q, tab_q, rab_q, irq_q;

  logic [3:0]        plan_beats;
  logic [LEN_W-1:0]  plan_need, step;
  logic              fifo_ok, in_data, rty_inc, rty_clr, rty_hit, any_abort;

  pkt_tx_plan #(.LEN_W(LEN_W)) u_plan (
    .rem_i(rem_q), .left_i(left_q), .bcfg_i(bcfg_q),
    .beats_o(plan_beats), .need_o(plan_need)
  );

  pkt_tx_be #(.LEN_W(LEN_W)) u_be (
    .rem_i(rem_q), .lo_half_i(half_q), .be_o(be_o)
  );

  assign in_data = (st_q == ST_DATA);
  assign rty_inc = in_data && tgt_retry_i && !tgt_mabort_i && !tgt_tabort_i;
  assign rty_clr = (st_q == ST_IDLE && start_i)
                || (st_q == ST_WAIT && rem_q == '0)
                || (in_data && (tgt_mabort_i || tgt_tabort_i));

  pkt_tx_retry #(.RTY_W(RTY_W)) u_retry (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(rty_clr), .inc_i(rty_inc),
    .lim_i(lim_q), .hit_o(rty_hit)
  );

  assign fifo_ok = {{LVL_W{1'b0}}, plan_need} <= CMP_W'(fifo_level_i);
  assign step    = (rem_q >= LEN_W'(4)) ? LEN_W'(4) : rem_q;

  assign fifo_pop_o = in_data && tgt_ack_i && !tgt_retry_i && !tgt_mabort_i && !tgt_tabort_i;
  assign req_o        = (st_q == ST_ADDR);
  assign cmd_o        = cmd_q;
  assign addr_o       = addr_q;
  assign beats_o      = cur_beats_q;
  assign beat_valid_o = in_data;
  assign data_o       = fifo_data_i;
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o        = done_q;
  assign abort_mst_o   = mab_q;
  assign abort_tgt_o   = tab_q;
  assign abort_retry_o = rab_q;
  assign irq_o         = irq_q;
  assign any_abort     = mab_q || tab_q || rab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cmd_q       <= CMD_MEM_WR;
      bcfg_q      <= '0;
      lim_q       <= '0;
      half_q      <= 1'b0;
      fix_q       <= 1'b0;
      addr_q      <= '0;
      base_q      <= '0;
      rem_q       <= '0;
      cur_beats_q <= '0;
      left_q      <= '0;
      done_q      <= 1'b0;
      mab_q       <= 1'b0;
      tab_q       <= 1'b0;
      rab_q       <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          cmd_q  <= cfg_cmd_i;
          bcfg_q <= cfg_beats_i;
          lim_q  <= cfg_rty_lim_i;
          half_q <= cfg_lo_half_i;
          fix_q  <= cfg_fix_addr_i;
          addr_q <= pkt_addr_i;
          base_q <= pkt_addr_i;
          rem_q  <= pkt_len_i;
          left_q <= '0;
          done_q <= 1'b0;
          mab_q  <= 1'b0;
          tab_q  <= 1'b0;
          rab_q  <= 1'b0;
          st_q   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rem_q == '0) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (fifo_ok) begin
            cur_beats_q <= plan_beats;
            left_q      <= plan_beats;
            st_q        <= ST_ADDR;
          end
        end
        ST_ADDR: st_q <= ST_DATA;
        ST_DATA: begin
          if (tgt_mabort_i) begin
            mab_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else if (tgt_tabort_i) begin
            tab_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else if (tgt_retry_i) begin
            if (rty_hit) begin
              rab_q <= 1'b1;
              irq_q <= 1'b1;
              st_q  <= ST_IDLE;
            end else begin
              st_q <= ST_WAIT;  // reissue from this beat, left_q kept
            end
          end else if (tgt_ack_i) begin
            rem_q  <= rem_q - step;
            left_q <= left_q - 4'd1;
            if (!fix_q) addr_q <= addr_q + ADDR_W'(4);
            if (left_q == 4'd1) st_q <= ST_WAIT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  beats_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (beats_o >= 4'd1 && beats_o <= 4'd8));

  // R4
  burst_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && beats_o > 4'd1) |-> (rem_q >= LEN_W'({beats_o, 2'b00})));

  // R7
  lo_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && half_q) |-> (be_o[3:2] == 2'b00));

  // R8
  fixed_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && fix_q) |-> (addr_o == base_q));

  // R10
  pop_in_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> beat_valid_o);

  // R10
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_abort |-> !busy_o);

  // R11
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(cmd_q) && $stable(bcfg_q) && $stable(lim_q)));

  // R6
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (abort_retry_o && lim_q != '0));

  // R6
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R13
  status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && any_abort));
endmodule

// File: tb/pkt_burst_tx_bench.sv
`timescale 1ns/1ps
module pkt_burst_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] pkt_len = '0;
  logic [31:0] pkt_addr = '0;
  logic [3:0]  cfg_cmd = 4'h7;
  logic [2:0]  cfg_beats = '0;
  logic [7:0]  cfg_lim = '0;
  logic        cfg_half = 1'b0, cfg_fix = 1'b0;
  logic [7:0]  lvl = 8'd255;
  logic [31:0] fifo_data = '0;
  logic        tgt_ack = 1'b0, tgt_retry = 1'b0, tgt_mab = 1'b0, tgt_tab = 1'b0;

  logic        fifo_pop_o, req_o, beat_valid_o, busy_o, done_o;
  logic        abort_mst_o, abort_tgt_o, abort_retry_o, irq_o;
  logic [3:0]  cmd_o, beats_o, be_o;
  logic [31:0] addr_o, data_o;

  pkt_burst_tx u_pkt_burst_tx (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pkt_len_i(pkt_len),
    .pkt_addr_i(pkt_addr), .cfg_cmd_i(cfg_cmd), .cfg_beats_i(cfg_beats),
    .cfg_rty_lim_i(cfg_lim), .cfg_lo_half_i(cfg_half), .cfg_fix_addr_i(cfg_fix),
    .fifo_level_i(lvl), .fifo_data_i(fifo_data), .fifo_pop_o(fifo_pop_o),
    .req_o(req_o), .cmd_o(cmd_o), .addr_o(addr_o), .beats_o(beats_o),
    .beat_valid_o(beat_valid_o), .data_o(data_o), .be_o(be_o),
    .tgt_ack_i(tgt_ack), .tgt_retry_i(tgt_retry), .tgt_mabort_i(tgt_mab),
    .tgt_tabort_i(tgt_tab), .busy_o(busy_o), .done_o(done_o),
    .abort_mst_o(abort_mst_o), .abort_tgt_o(abort_tgt_o),
    .abort_retry_o(abort_retry_o), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  localparam logic [31:0] BASE = 32'h1000_0100;
  localparam logic [31:0] DPAT = 32'hA500_0000;

  int n_chk = 0, n_bad = 0;
  int m_rem, m_left, m_nb, m_acc, m_rty, n_trans, pops, irq_cnt;
  int mode = 0, k_at = 0, r_n = 0;
  logic [31:0] m_addr;
  logic        m_fix, m_half;
  logic [3:0]  m_cmd;
  bit          finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // target model and per-beat checks, away from the active edge
  always @(negedge clk) begin
    logic [3:0] exp_be;
    tgt_ack = 1'b0; tgt_retry = 1'b0; tgt_mab = 1'b0; tgt_tab = 1'b0;
    if (req_o) begin
      if (m_left == 0) m_left = (m_rem >= 4 * m_nb) ? m_nb : 1;
      n_trans++;
      chk(addr_o == m_addr, "R8 R9 address phase", addr_o, m_addr);
      chk(beats_o == m_left, "R2 R4 R9 beat count", beats_o, m_left);
      chk(cmd_o == m_cmd, "R1 R11 command", cmd_o, m_cmd);
    end
    if (beat_valid_o) begin
      if (mode == 3 && m_acc == k_at) tgt_mab = 1'b1;
      else if (mode == 4 && m_acc == k_at) tgt_tab = 1'b1;
      else if (mode == 1 && m_acc == k_at && m_rty < r_n) begin
        tgt_retry = 1'b1;
        m_rty++;
      end else begin
        tgt_ack = 1'b1;
        exp_be = (m_rem >= 4) ? 4'hF : 4'((1 << m_rem) - 1);
        if (m_half) exp_be = exp_be & 4'h3;
        chk(be_o == exp_be, "R7 R12 byte enables", be_o, exp_be);
        chk(data_o == DPAT + 32'(m_acc), "R13 beat data", data_o, DPAT + 32'(m_acc));
        m_rem = m_rem - ((m_rem >= 4) ? 4 : m_rem);
        if (!m_fix) m_addr = m_addr + 32'd4;
        m_left--;
        m_acc++;
      end
    end
    fifo_data = DPAT + 32'(m_acc);
  end

  always @(posedge clk) begin
    if (fifo_pop_o) pops++;
    if (irq_o) irq_cnt++;
  end

  task automatic run_pkt(input int len, input int bt, input bit half, input bit fix,
                         input int lim, input int md, input int k, input int rn,
                         input int gate, input bit poke, input logic [3:0] cmd);
    int guard;
    int exp_words, exp_trans, tl;
    cfg_cmd = cmd; cfg_beats = 3'(bt); cfg_half = half; cfg_fix = fix;
    cfg_lim = 8'(lim); pkt_len = 16'(len); pkt_addr = BASE;
    m_rem = len; m_addr = BASE; m_left = 0; m_nb = (bt == 0) ? 8 : bt;
    m_acc = 0; m_rty = 0; n_trans = 0; pops = 0; irq_cnt = 0;
    mode = md; k_at = k; r_n = rn; m_fix = fix; m_half = half; m_cmd = cmd;
    lvl = (gate != 0) ? 8'(gate - 1) : 8'd255;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy_o && !done_o && !abort_mst_o && !abort_tgt_o && !abort_retry_o,
        "R13 flags cleared at start", {busy_o, done_o, abort_retry_o}, 3'b100);
    if (poke) begin
      pkt_len = 16'd4; cfg_cmd = ~cmd; cfg_beats = 3'(bt + 1); start = 1'b1;
      @(negedge clk) start = 1'b0;
      cfg_cmd = cmd;
    end
    if (gate != 0) begin
      repeat (25) @(negedge clk);
      chk(n_trans == 0, "R3 held below need", n_trans, 0);
      lvl = 8'(gate);
    end
    guard = 0;
    while (busy_o && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 3000, "R13 packet finishes", guard, 0);
    @(negedge clk);
    exp_words = (len + 3) / 4;
    if (md == 3) begin
      chk(abort_mst_o && !done_o, "R10 master abort flag", abort_mst_o, 1);
      chk(pops == k, "R10 no pop after abort", pops, k);
    end else if (md == 4) begin
      chk(abort_tgt_o && !done_o, "R10 target abort flag", abort_tgt_o, 1);
      chk(pops == k, "R10 no pop after abort", pops, k);
    end else if (md == 1 && lim != 0 && rn >= lim) begin
      chk(abort_retry_o && !done_o, "R6 retry abort flag", abort_retry_o, 1);
      chk(irq_cnt == 1, "R6 single irq pulse", irq_cnt, 1);
      chk(m_rty == lim, "R6 retries before abort", m_rty, lim);
      chk(pops == k, "R6 pops before abort", pops, k);
    end else begin
      chk(done_o && !abort_mst_o && !abort_tgt_o && !abort_retry_o,
          "R13 done flag", {done_o, abort_retry_o}, 2'b10);
      chk(irq_cnt == 0, "R6 no irq", irq_cnt, 0);
      chk(pops == exp_words, "R11 R13 words popped", pops, exp_words);
      if (md == 0) begin
        tl = len % (4 * m_nb);
        exp_trans = len / (4 * m_nb) + (tl + 3) / 4;
        chk(n_trans == exp_trans, "R4 transaction count", n_trans, exp_trans);
      end
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_o == 4'h7, "R1 reset command", cmd_o, 4'h7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !req_o && !beat_valid_o && !fifo_pop_o, "R13 idle after reset",
        {busy_o, req_o, beat_valid_o}, 0);
    chk(!done_o && !irq_o && !abort_retry_o, "R13 status after reset", {done_o, irq_o}, 0);
    chk(cmd_o == 4'h7, "R1 command after reset", cmd_o, 4'h7);

    // sweep: all burst settings, lengths 1..33, lane and address modes
    for (int bt = 0; bt < 8; bt++)
      for (int len = 1; len <= 33; len++)
        for (int md4 = 0; md4 < 4; md4++)
          run_pkt(len, bt, md4[0], md4[1], 0, 0, 0, 0, 0, 1'b0, 4'(bt + len));

    // R3 admission: full burst and short tail
    run_pkt(32, 4, 1'b0, 1'b0, 0, 0, 0, 0, 16, 1'b0, 4'h7);
    run_pkt(2, 0, 1'b0, 1'b0, 0, 0, 0, 0, 2, 1'b0, 4'h7);

    // R9 reissue mid-burst, incrementing and fixed address
    run_pkt(16, 4, 1'b0, 1'b0, 0, 1, 2, 1, 0, 1'b0, 4'h7);
    run_pkt(22, 4, 1'b1, 1'b1, 0, 1, 1, 2, 0, 1'b0, 4'h3);
    run_pkt(9, 0, 1'b0, 1'b0, 0, 1, 2, 1, 0, 1'b0, 4'h7);

    // R6 limits
    run_pkt(16, 4, 1'b0, 1'b0, 3, 1, 1, 99, 0, 1'b0, 4'h7);
    run_pkt(16, 4, 1'b0, 1'b0, 1, 1, 0, 99, 0, 1'b0, 4'h7);
    run_pkt(16, 4, 1'b0, 1'b0, 0, 1, 0, 20, 0, 1'b0, 4'h7);

    // R5 counter cleared between packets
    run_pkt(12, 1, 1'b0, 1'b0, 2, 1, 1, 1, 0, 1'b0, 4'h7);
    run_pkt(12, 1, 1'b0, 1'b0, 2, 1, 2, 1, 0, 1'b0, 4'h7);
    run_pkt(12, 1, 1'b0, 1'b0, 3, 1, 2, 2, 0, 1'b0, 4'h7);

    // R10 aborts
    run_pkt(20, 2, 1'b0, 1'b0, 0, 3, 3, 0, 0, 1'b0, 4'h7);
    run_pkt(20, 2, 1'b0, 1'b0, 0, 4, 0, 0, 0, 1'b0, 4'h7);
    run_pkt(8, 2, 1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b0, 4'h7);

    // R11 start while busy ignored
    run_pkt(24, 2, 1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b1, 4'h3);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule